// File: doc/BRIEF.md
# Reset-Time Configuration Strap Decoder

When reset is released, this block samples a small set of board strap levels. It passes them through a two-stage synchronizer and freezes them. It then turns them into the system configuration: which host transport is in use (UART or USB), which reference-frequency code the clock logic should use, and whether boot runs from internal ROM or from external flash. The frequency decode is prioritized. Choosing USB overrides every frequency strap. With UART, a second strap picks between a non-volatile setting and a pull-up strap. The non-volatile setting falls back to the 32 MHz code when it is not valid.

Boot source is found by a short tie test. The block drives one data line low and then high, and watches a second data line. If the second line follows both levels, the two lines are joined on the board, and internal ROM is selected. After the test the driver is released. A single-cycle `cfg_valid` strobe marks the moment all outputs carry their final values. The outputs then hold until the next reset.

Top module: `strap_cfg_decoder`

## Requirements
- R1: While `rst_n` is low, `xport_usb`, `ref_code`, `ref_nvm_val`, `boot_int`, `cfg_valid` and `d9_drive` are 0, and `d9_oe` is 1.
- R2: `strap_xport` = 0 selects UART (`xport_usb` = 0). `strap_xport` = 1 selects USB (`xport_usb` = 1).
- R3: With USB selected, `ref_code` is 0 (32 MHz) whatever `strap_fsel`, `strap_pullup` and the non-volatile inputs are.
- R4: With UART and `strap_fsel` = 1, `ref_code` is 3 (use the non-volatile value) and `ref_nvm_val` equals `nvm_freq_val` when `nvm_freq_ok` = 1. Otherwise `ref_code` is 0 (32 MHz).
- R5: With UART and `strap_fsel` = 0, `ref_code` is 1 (13 MHz) when `strap_pullup` = 0, and 2 (26 MHz) when it is 1.
- R6: `ref_nvm_val` is 0 whenever `ref_code` is not 3.
- R7: The strap pins are sampled at the first rising clock edge after `rst_n` goes high. Changes to them later have no effect on the result.
- R8: Counting rising edges after release from 1, `d9_oe` stays high through edge 2*PHASE and is low from edge 2*PHASE+1 on. `d9_drive` is low after edges 1..PHASE-1 and high after edges PHASE..2*PHASE.
- R9: `boot_int` = 1 only if `d10_sense` followed both the low and the high level of `d9_drive`. A line stuck at either level gives 0 (external flash).
- R10: `cfg_valid` is high for exactly one cycle, after edge 2*PHASE+1. The non-volatile inputs are taken at that same edge. From then on, all configuration outputs hold until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| strap_xport | input | 1 | Transport strap: 0 UART, 1 USB |
| strap_fsel | input | 1 | Frequency source strap: 1 non-volatile, 0 pull-up strap |
| strap_pullup | input | 1 | Pull-up strap: 0 13 MHz, 1 26 MHz |
| nvm_freq_ok | input | 1 | Non-volatile frequency parameter is present |
| nvm_freq_val | input | NVM_W | Non-volatile frequency parameter value |
| d10_sense | input | 1 | Level read back on the second data line |
| d9_drive | output | 1 | Test level driven on the first data line |
| d9_oe | output | 1 | Output enable for the test driver |
| xport_usb | output | 1 | Selected transport, 1 = USB |
| ref_code | output | 2 | 0 32 MHz, 1 13 MHz, 2 26 MHz, 3 non-volatile |
| ref_nvm_val | output | NVM_W | Non-volatile value when `ref_code` is 3, else 0 |
| boot_int | output | 1 | 1 internal ROM, 0 external flash |
| cfg_valid | output | 1 | One-cycle strobe: configuration ready |

## Verification
Three things happen on the same clock edge: the tie test takes its second reading, the frequency decode samples the non-volatile flag and value, and the strobe fires. The bench provokes this by holding the non-volatile inputs and the line behaviour through that edge, then flipping the non-volatile inputs and all straps immediately after it. It judges the result by checking that the registered outputs keep the values decoded at the strobe, and that they match the vectors worked out from the decode rules for tied, stuck-low and stuck-high lines.

// File: rtl/strap_cfg_decoder.sv
module strap_cfg_decoder #(
  parameter int NVM_W = 8,
  parameter int PHASE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_xport,
  input  logic             strap_fsel,
  input  logic             strap_pullup,
  input  logic             nvm_freq_ok,
  input  logic [NVM_W-1:0] nvm_freq_val,
  input  logic             d10_sense,
  output logic             d9_drive,
  output logic             d9_oe,
  output logic             xport_usb,
  output logic [1:0]       ref_code,
  output logic [NVM_W-1:0] ref_nvm_val,
  output logic             boot_int,
  output logic             cfg_valid
);
  localparam int LAST = 2 * PHASE;
  localparam int CW = $clog2(LAST + 2);
  localparam logic [CW-1:0] C_CAP  = CW'(2);
  localparam logic [CW-1:0] C_LO   = CW'(PHASE);
  localparam logic [CW-1:0] C_LAST = CW'(LAST);
  localparam logic [CW-1:0] C_DONE = CW'(LAST + 1);

  logic [CW-1:0] cnt;
  logic [3:0]    sync1, sync2;
  logic [2:0]    strap_q;
  logic          d10_lo_q;
  logic [1:0]    code_d;

  assign d9_oe    = (cnt != C_DONE);
  assign d9_drive = d9_oe && (cnt >= C_LO);

  always_comb begin
    if (strap_q[2])      code_d = 2'd0;
    else if (strap_q[1]) code_d = nvm_freq_ok ? 2'd3 : 2'd0;
    else                 code_d = strap_q[0] ? 2'd2 : 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      sync1       <= '0;
      sync2       <= '0;
      strap_q     <= '0;
      d10_lo_q    <= 1'b0;
      xport_usb   <= 1'b0;
      ref_code    <= 2'd0;
      ref_nvm_val <= '0;
      boot_int    <= 1'b0;
      cfg_valid   <= 1'b0;
    end else begin
      sync1     <= {d10_sense, strap_xport, strap_fsel, strap_pullup};
      sync2     <= sync1;
      cfg_valid <= (cnt == C_LAST);
      if (cnt != C_DONE) cnt <= cnt + 1'b1;
      if (cnt == C_CAP)  strap_q <= sync2[2:0];
      if (cnt == C_LO)   d10_lo_q <= sync2[3];
      if (cnt == C_LAST) begin
        xport_usb   <= strap_q[2];
        ref_code    <= code_d;
        ref_nvm_val <= (code_d == 2'd3) ? nvm_freq_val : '0;
        boot_int    <= !d10_lo_q && sync2[3];
      end
    end
  end

  a_r10_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> !cfg_valid);
  a_r10_outputs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == C_DONE && $past(cnt) == C_DONE) |->
      ($stable(ref_code) && $stable(xport_usb) && $stable(boot_int) && $stable(ref_nvm_val)));
  a_r3_usb_forces_32m: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && xport_usb) |-> (ref_code == 2'd0));
  a_r6_nvm_val_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_code != 2'd3) |-> (ref_nvm_val == '0));
  a_r8_driver_released: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (!d9_oe && !d9_drive));
endmodule

// File: tb/sim_strap_cfg_decoder.sv
`timescale 1ns/1ps
module sim_strap_cfg_decoder;
  localparam int NVM_W = 8;
  localparam int PHASE = 4;
  localparam int LAST  = 2 * PHASE;
  localparam int NV    = 8;
  // {xport, fsel, pullup, nvm_ok, tie[1:0], exp_code[1:0], exp_boot}; tie: 0 joined, 1 stuck low, 2 stuck high
  localparam logic [8:0] VEC [0:NV-1] = '{
    9'b0000_00_01_1, 9'b0010_01_10_0, 9'b0101_00_11_1, 9'b0110_10_00_0,
    9'b1001_00_00_1, 9'b1111_10_00_0, 9'b1010_01_00_0, 9'b0100_00_00_1
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic strap_xport = 0, strap_fsel = 0, strap_pullup = 0, nvm_freq_ok = 0;
  logic [NVM_W-1:0] nvm_freq_val = '0;
  logic [1:0] tie = 2'd0;
  logic d10_sense, d9_drive, d9_oe, xport_usb, boot_int, cfg_valid;
  logic [1:0] ref_code;
  logic [NVM_W-1:0] ref_nvm_val;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  assign d10_sense = (tie == 2'd0) ? d9_drive : (tie == 2'd2);

  strap_cfg_decoder #(.NVM_W(NVM_W), .PHASE(PHASE)) u0 (
    .clk(clk), .rst_n(rst_n), .strap_xport(strap_xport), .strap_fsel(strap_fsel),
    .strap_pullup(strap_pullup), .nvm_freq_ok(nvm_freq_ok), .nvm_freq_val(nvm_freq_val),
    .d10_sense(d10_sense), .d9_drive(d9_drive), .d9_oe(d9_oe), .xport_usb(xport_usb),
    .ref_code(ref_code), .ref_nvm_val(ref_nvm_val), .boot_int(boot_int), .cfg_valid(cfg_valid));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1", {xport_usb, ref_code, boot_int, cfg_valid, d9_drive, d9_oe}, 7'b0000001);
    chk("R1 nvm", ref_nvm_val, 0);

    for (int i = 0; i < NV; i++) begin
      logic [8:0] v;
      logic [NVM_W-1:0] nv;
      logic [1:0] ec;
      int bad_v, bad_d;
      v = VEC[i];
      nv = NVM_W'(8'h51 + 8'(i * 17));
      ec = v[2:1];
      do_reset();
      {strap_xport, strap_fsel, strap_pullup, nvm_freq_ok} = v[8:5];
      tie = v[4:3];
      nvm_freq_val = nv;
      @(negedge clk); rst_n = 1'b1;
      bad_v = 0; bad_d = 0;
      for (int e = 1; e <= LAST + 2; e++) begin
        @(negedge clk);
        if (cfg_valid !== (e == LAST + 1)) bad_v++;
        if (d9_oe !== (e <= LAST)) bad_d++;
        if (d9_drive !== (e >= PHASE && e <= LAST)) bad_d++;
        if (e == LAST + 1) begin
          chk($sformatf("R2 vec%0d", i), xport_usb, v[8]);
          chk($sformatf("R3/R4/R5 vec%0d", i), ref_code, ec);
          chk($sformatf("R4/R6 vec%0d", i), ref_nvm_val, (ec == 2'd3) ? nv : 0);
          chk($sformatf("R9 vec%0d", i), boot_int, v[0]);
          // R10: flip non-volatile inputs and straps right after the decode edge
          nvm_freq_ok = ~nvm_freq_ok; nvm_freq_val = ~nvm_freq_val;
          strap_xport = ~strap_xport; strap_fsel = ~strap_fsel; strap_pullup = ~strap_pullup;
          tie = 2'd1;
        end
      end
      chk($sformatf("R10 strobe vec%0d", i), bad_v, 0);
      chk($sformatf("R8 driver vec%0d", i), bad_d, 0);
      repeat (3) @(negedge clk);
      chk($sformatf("R10 hold vec%0d", i), {xport_usb, ref_code, boot_int}, {v[8], ec, v[0]});
    end

    // R7: straps change after the first edge -> first-edge values kept
    do_reset();
    {strap_xport, strap_fsel, strap_pullup, nvm_freq_ok} = 4'b0010; tie = 2'd0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    {strap_xport, strap_fsel, strap_pullup} = 3'b101;
    repeat (LAST) @(negedge clk);
    chk("R7 valid", cfg_valid, 1'b1);
    chk("R7 usb", xport_usb, 1'b0);
    chk("R7 code", ref_code, 2'd2);

    // R7: straps absent at the first edge only appear too late
    do_reset();
    {strap_xport, strap_fsel, strap_pullup} = 3'b000;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    strap_xport = 1'b1;
    repeat (LAST) @(negedge clk);
    chk("R7 late usb", xport_usb, 1'b0);
    chk("R5 late code", ref_code, 2'd1);

    // R3: USB with every other input set still gives code 0
    do_reset();
    {strap_xport, strap_fsel, strap_pullup, nvm_freq_ok} = 4'b1111; nvm_freq_val = 8'hFF;
    @(negedge clk); rst_n = 1'b1;
    repeat (LAST + 1) @(negedge clk);
    chk("R3 usb code", ref_code, 2'd0);
    chk("R6 usb nvm", ref_nvm_val, 0);

    // R1 again during a mid-sequence reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 re-reset", {xport_usb, ref_code, boot_int, cfg_valid, d9_oe}, 6'b000001);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule